// File: doc/BRIEF.md
# Three-Mode Arithmetic Unit with Unsigned Compare

This block is the arithmetic stage of a small register-based processor. It takes the values read from the two source registers and an operation selector. It returns one result word and a flag that is high when that word is zero. Three operations are defined: wrapping addition, wrapping subtraction, and an unsigned less-than compare. The compare takes the borrow out of the subtractor and widens it with zeros. The operation selector has room for eight codes, so later modes can be added. For now, every code without an assigned meaning yields a zero word.

A single multiplexer at the end of the datapath picks the mode result. The zero detector looks at that selected word, so the flag always describes the value that is actually delivered. Result and flag are registered together on the rising clock edge, with a synchronous active-high reset. The instruction decoder can branch on the flag in the cycle after the operation was issued.

Top module: `cmpalu`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q` becomes 0 and `zero_q` becomes 1 at that edge.
- R2: With `op_sel` = 0 (add) at a rising edge, `res_q` becomes (`opnd_a` + `opnd_b`) modulo 2^16 at that edge.
- R3: With `op_sel` = 1 (subtract), `res_q` becomes (`opnd_a` - `opnd_b`) modulo 2^16.
- R4: With `op_sel` = 2 (compare), `res_q` becomes 1 when `opnd_a` is less than `opnd_b` as unsigned numbers, and 0 otherwise. Bits 15 down to 1 of `res_q` are always 0 in this mode.
- R5: With `op_sel` set to any of the codes 3 to 7, `res_q` becomes 0.
- R6: `zero_q` is 1 exactly when `res_q` is 0, in every mode, including the compare mode and the unused codes.
- R7: Each operation produces its result and flag at the first rising edge after it is presented. Back-to-back operations yield one result per cycle. Between edges the outputs do not change when the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 unsigned compare, 3-7 unused |
| opnd_a | input | 16 | First source register value |
| opnd_b | input | 16 | Second source register value |
| res_q | output | 16 | Registered result word |
| zero_q | output | 1 | Registered flag, high when the result word is zero |

## Verification
The result word and the flag are both due at the first rising edge after the operands and code are driven, which is one register stage. The bench changes inputs on the falling edge. It samples the outputs shortly after the next rising edge, so each check looks at exactly the operation applied half a cycle earlier. To confirm that nothing leaks through between edges, the outputs are also sampled just after new inputs are driven, before the edge, and must still hold the previous operation's values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_LTU = 3'd2
    } op_e;

    function automatic logic is_defined_op(input logic [OP_W-1:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_LTU);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         borrow
);
    logic [W:0] sub_ext;

    always_comb begin
        sum     = a + b;
        sub_ext = {1'b0, a} - {1'b0, b};
        diff    = sub_ext[W-1:0];
        borrow  = sub_ext[W];
    end

    // R4: borrow out of the subtractor must agree with unsigned less-than
    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r4_borrow_is_ltu: assert (borrow == (a < b));
        end
    end

endmodule

// File: rtl/alu_sel.sv
module alu_sel #(
    parameter int W  = alu_pkg::DATA_W,
    parameter int OW = alu_pkg::OP_W
) (
    input  logic [OW-1:0] op,
    input  logic [W-1:0]  sum,
    input  logic [W-1:0]  diff,
    input  logic          borrow,
    output logic [W-1:0]  y
);
    import alu_pkg::*;

    localparam int PAD_W = W - 1;

    logic [W-1:0] ltu_word;

    assign ltu_word = {{PAD_W{1'b0}}, borrow};

    always_comb begin
        case (op)
            OP_ADD:  y = sum;
            OP_SUB:  y = diff;
            OP_LTU:  y = ltu_word;
            default: y = '0;
        endcase
    end

    // R5: an unused code must leave the mux output at zero
    always_comb begin
        if (!$isunknown(op) && !is_defined_op(op)) begin
            a_r5_unused_code_zero: assert (y == '0);
        end
    end

endmodule

// File: rtl/alu_zdet.sv
module alu_zdet #(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] y,
    output logic         is_zero
);
    assign is_zero = ~|y;
endmodule

// File: rtl/cmpalu.sv
module cmpalu #(
    parameter int W  = alu_pkg::DATA_W,
    parameter int OW = alu_pkg::OP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] op_sel,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic [W-1:0]  res_q,
    output logic          zero_q
);
    import alu_pkg::*;

    logic [W-1:0] sum_w;
    logic [W-1:0] diff_w;
    logic         brw_w;
    logic [W-1:0] sel_w;
    logic         zero_w;

    alu_arith #(.W(W)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .sum    (sum_w),
        .diff   (diff_w),
        .borrow (brw_w)
    );

    alu_sel #(.W(W), .OW(OW)) u_sel (
        .op     (op_sel),
        .sum    (sum_w),
        .diff   (diff_w),
        .borrow (brw_w),
        .y      (sel_w)
    );

    alu_zdet #(.W(W)) u_zdet (
        .y       (sel_w),
        .is_zero (zero_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            zero_q <= 1'b1;
        end else begin
            res_q  <= sel_w;
            zero_q <= zero_w;
        end
    end

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (res_q == '0) && zero_q);

    // R2: add mode, one cycle later
    a_r2_add_wraps: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ADD) |=> (res_q == W'($past(opnd_a) + $past(opnd_b))));

    // R3: subtract mode, one cycle later
    a_r3_sub_wraps: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_SUB) |=> (res_q == W'($past(opnd_a) - $past(opnd_b))));

    // R4: compare result only ever occupies bit 0
    a_r4_ltu_one_bit: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_LTU) |=> (res_q[W-1:1] == '0));

    // R6: flag tracks the registered word
    a_r6_flag_matches: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (zero_q == (res_q == '0)));

endmodule

// File: tb/cmpalu_bench.sv
module cmpalu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] res_q;
    logic        zero_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cmpalu u_cmpalu (
        .clk    (clk),
        .rst    (rst),
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .res_q  (res_q),
        .zero_q (zero_q)
    );

    function automatic logic [15:0] model(input logic [2:0] op,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
        case (op)
            3'd0:    return a + b;
            3'd1:    return a - b;
            3'd2:    return (a < b) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive on falling edge, result due at next rising edge, sample 2 ns after it
    task automatic apply(input string tag, input logic [2:0] op,
                         input logic [15:0] a, input logic [15:0] b);
        logic [15:0] e;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        e = model(op, a, b);
        @(posedge clk); #2;
        chk(tag, res_q, e);
        chk({tag, " R6 flag"}, {15'd0, zero_q}, {15'd0, (e == 16'd0)});
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 result after reset", res_q, 16'd0);
        chk("R1 flag after reset", {15'd0, zero_q}, 16'd1);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_add;
        apply("R2 add small", 3'd0, 16'd1234, 16'd4321);
        apply("R2 add wrap", 3'd0, 16'hFFFF, 16'h0002);
        apply("R2 add wrap to zero", 3'd0, 16'h8000, 16'h8000);
    endtask

    task automatic t_sub;
        apply("R3 sub plain", 3'd1, 16'd500, 16'd123);
        apply("R3 sub underflow", 3'd1, 16'd3, 16'd5);
        apply("R3 sub equal", 3'd1, 16'hABCD, 16'hABCD);
    endtask

    task automatic t_ltu;
        apply("R4 lt", 3'd2, 16'd7, 16'd9);
        apply("R4 gt", 3'd2, 16'd9, 16'd7);
        apply("R4 equal", 3'd2, 16'h5555, 16'h5555);
        apply("R4 unsigned high", 3'd2, 16'h8000, 16'h0001);
        apply("R4 unsigned low", 3'd2, 16'h0001, 16'hFFFF);
    endtask

    task automatic t_unused;
        for (int c = 3; c < 8; c++) begin
            apply("R5 unused code", 3'(c), 16'h1111, 16'h0001);
        end
    endtask

    task automatic t_timing;
        apply("R7 first", 3'd0, 16'd10, 16'd20);
        @(negedge clk);
        op_sel = 3'd1; opnd_a = 16'd100; opnd_b = 16'd1;
        #1;
        chk("R7 hold before edge", res_q, 16'd30);
        @(posedge clk); #2;
        chk("R7 next cycle", res_q, 16'd99);
        apply("R7 back to back", 3'd2, 16'd0, 16'd1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #2;
        chk("R1 reset mid run", res_q, 16'd0);
        chk("R1 flag mid run", {15'd0, zero_q}, 16'd1);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_ltu();
        t_unused();
        t_timing();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule